// File: doc/BRIEF.md
# Binary-Search Oscillator Code Calibrator

This block finds the 8-bit control code for a voltage-controlled oscillator. The code is chosen so that the oscillator's divided output runs at the reference clock frequency. The code drives a DAC. The oscillator and its fixed divider sit outside the block, and only the divided clock comes back in.

A calibration run resolves one code bit per trial, starting at the most significant bit. Each trial runs in three steps:
- The code is held still while the oscillator settles.
- Feedback edges are counted over a fixed window of reference cycles.
- The count is compared with the window length. A slow result keeps the trial bit and a fast result drops it.

A last window at the final code decides whether the loop is close enough to report lock.

The feedback edge counter runs in the feedback clock domain as a Gray-coded counter. It reaches the reference domain through a two-flop synchronizer. Window counts are taken as the difference of two snapshots, so the feedback domain never has to be cleared.

Top module: `vco_sar_cal`

## Requirements
- R1: After reset, `code` is 0x80, and `busy`, `done` and `locked` are low.
- R2: A `start` pulse seen while idle or done loads `code` with 0x80, raises `busy` and clears `done` and `locked` by the next cycle.
- R3: Each trial idles for SETTLE_CYC reference cycles and then counts feedback edges over WIN_CYC reference cycles. `code` does not change during either phase.
- R4: Code 0x00 is the slowest oscillator setting and 0xFF the fastest. A count below WIN_CYC (too slow) keeps the trial bit set; a count of WIN_CYC or more clears it. The next lower bit is then set as the new trial.
- R5: A run makes eight decisions from bit 7 down to bit 0, then one verify window at the final code. `busy` stays high for exactly 9*(SETTLE_CYC+WIN_CYC+1) reference cycles.
- R6: When a run finishes, `done` goes high and `busy` goes low. `code` then stays fixed until the next `start`.
- R7: `locked` is raised with `done` only if the verify count is within LOCK_TOL of WIN_CYC. `locked` is never high without `done`.
- R8: A `start` pulse while `busy` is high has no effect on the code sequence or on the run length.
- R9: A target above the oscillator's range ends at code 0xFF with `locked` low. A target below its range ends at code 0x00 with `locked` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference clock; all control logic runs on it |
| rstN | input | 1 | Asynchronous active-low reset for both clock domains |
| start | input | 1 | Pulse to begin a calibration run |
| fbClk | input | 1 | Divided oscillator clock being measured |
| code | output | 8 | Oscillator control code to the DAC |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | High once a run has finished, until the next start |
| locked | output | 1 | Final verify count within tolerance |

## Verification
The bench models the oscillator as a frequency proportional to the code plus an offset.

The first tests target the first decision in both directions: 0x80 must turn into 0x40 for a fast oscillator and into 0xC0 for a slow one. A wrong comparison sense would drive the search to the opposite rail.

The run length is measured to the cycle. An off-by-one settle or window counter, or a skipped verify window, changes that count.

Targets outside the range at both ends check that the search saturates cleanly and that lock is refused. A stray `start` in mid-run and a long hold after `done` show whether the code can be disturbed when it must not move.

// File: rtl/vco_sar_pkg.sv
package vco_sar_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_MEASURE,
    ST_JUDGE,
    ST_DONE
  } calState_e;

  // Single-cycle strobes from control to datapath
  typedef struct packed {
    logic init;      // load midpoint code, clear lock
    logic snapBase;  // capture feedback count at window start
    logic snapMeas;  // capture window count at window end
    logic apply;     // resolve current trial bit, set next trial
    logic finish;    // judge lock from verify window
  } calStrobe_t;

endpackage

// File: rtl/vco_sar_fbsync.sv
module vco_sar_fbsync #(
  parameter int CNT_W = 12
) (
  input  logic             fbClk,
  input  logic             refClk,
  input  logic             rstN,
  output logic [CNT_W-1:0] fbCountRef
);

  logic [CNT_W-1:0] binQ;
  logic [CNT_W-1:0] binNext;
  logic [CNT_W-1:0] grayQ;
  logic [CNT_W-1:0] syncA;
  logic [CNT_W-1:0] syncB;

  assign binNext = binQ + 1'b1;

  // Feedback domain: free-running count, registered Gray copy
  always_ff @(posedge fbClk or negedge rstN) begin
    if (!rstN) begin
      binQ  <= '0;
      grayQ <= '0;
    end else begin
      binQ  <= binNext;
      grayQ <= binNext ^ (binNext >> 1);
    end
  end

  // Reference domain: two-flop synchronizer
  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= grayQ;
      syncB <= syncA;
    end
  end

  // Gray to binary
  for (genvar i = 0; i < CNT_W; i++) begin : g_g2b
    assign fbCountRef[i] = ^(syncB >> i);
  end

  // R3: the crossing bus changes at most one bit per feedback edge
  p_gray_step_r3: assert property (@(posedge fbClk) disable iff (!rstN)
    $countones(grayQ ^ $past(grayQ)) <= 1);

endmodule

// File: rtl/vco_sar_dp.sv
module vco_sar_dp
  import vco_sar_pkg::*;
#(
  parameter int CODE_W   = 8,
  parameter int CNT_W    = 12,
  parameter int WIN_CYC  = 256,
  parameter int LOCK_TOL = 6,
  localparam int IDX_W   = $clog2(CODE_W)
) (
  input  logic              refClk,
  input  logic              rstN,
  input  calStrobe_t        st,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic [CNT_W-1:0]  fbCount,
  output logic [CODE_W-1:0] code,
  output logic              locked
);

  localparam logic [CODE_W-1:0] MID    = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CNT_W-1:0]  TARGET = CNT_W'(WIN_CYC);
  localparam logic [CNT_W-1:0]  TOL    = CNT_W'(LOCK_TOL);

  logic [CNT_W-1:0]  baseCnt;
  logic [CNT_W-1:0]  measCnt;
  logic [CNT_W-1:0]  errMag;
  logic [CODE_W-1:0] codeNext;
  logic              slow;
  logic              inTol;

  assign slow   = measCnt < TARGET;
  assign errMag = slow ? (TARGET - measCnt) : (measCnt - TARGET);
  assign inTol  = errMag <= TOL;

  always_comb begin
    codeNext = code;
    if (st.init) begin
      codeNext = MID;
    end else if (st.apply) begin
      if (!slow) codeNext[bitIdx] = 1'b0;
      if (bitIdx != '0) codeNext[bitIdx - 1'b1] = 1'b1;
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      baseCnt <= '0;
      measCnt <= '0;
      code    <= MID;
      locked  <= 1'b0;
    end else begin
      code <= codeNext;
      if (st.snapBase) baseCnt <= fbCount;
      if (st.snapMeas) measCnt <= fbCount - baseCnt;
      if (st.init)        locked <= 1'b0;
      else if (st.finish) locked <= inTol;
    end
  end

  // R3: code moves only on a load or a bit decision from control
  p_code_held_r3: assert property (@(posedge refClk) disable iff (!rstN)
    (!$past(st.init) && !$past(st.apply)) |-> $stable(code));

endmodule

// File: rtl/vco_sar_ctrl.sv
module vco_sar_ctrl
  import vco_sar_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int WIN_CYC    = 256,
  parameter int SETTLE_CYC = 8,
  localparam int IDX_W     = $clog2(CODE_W),
  localparam int MAXC      = (WIN_CYC > SETTLE_CYC) ? WIN_CYC : SETTLE_CYC,
  localparam int TMR_W     = $clog2(MAXC + 1)
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic             start,
  output calStrobe_t       st,
  output logic [IDX_W-1:0] bitIdx,
  output logic             busy,
  output logic             done
);

  calState_e        state;
  calState_e        stateNext;
  logic [TMR_W-1:0] timer;
  logic             verify;
  logic             settleEnd;
  logic             winEnd;

  assign settleEnd = timer == TMR_W'(SETTLE_CYC - 1);
  assign winEnd    = timer == TMR_W'(WIN_CYC - 1);
  assign busy      = (state == ST_SETTLE) || (state == ST_MEASURE) || (state == ST_JUDGE);
  assign done      = state == ST_DONE;

  always_comb begin
    st        = '0;
    stateNext = state;
    case (state)
      ST_IDLE, ST_DONE: if (start) begin
        st.init   = 1'b1;
        stateNext = ST_SETTLE;
      end
      ST_SETTLE: if (settleEnd) begin
        st.snapBase = 1'b1;
        stateNext   = ST_MEASURE;
      end
      ST_MEASURE: if (winEnd) begin
        st.snapMeas = 1'b1;
        stateNext   = ST_JUDGE;
      end
      ST_JUDGE: begin
        if (verify) begin
          st.finish = 1'b1;
          stateNext = ST_DONE;
        end else begin
          st.apply  = 1'b1;
          stateNext = ST_SETTLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      timer  <= '0;
      bitIdx <= '0;
      verify <= 1'b0;
    end else begin
      state <= stateNext;
      if (st.init) begin
        timer  <= '0;
        bitIdx <= IDX_W'(CODE_W - 1);
        verify <= 1'b0;
      end else if (st.snapBase || st.snapMeas) begin
        timer <= '0;
      end else if (state == ST_SETTLE || state == ST_MEASURE) begin
        timer <= timer + 1'b1;
      end
      if (st.apply) begin
        if (bitIdx == '0) verify <= 1'b1;
        else              bitIdx <= bitIdx - 1'b1;
      end
    end
  end

  // R6: a run is never both in progress and finished
  p_busy_done_excl_r6: assert property (@(posedge refClk) disable iff (!rstN)
    !(busy && done));

  // R5: every window end is followed by a judgement
  p_meas_judged_r5: assert property (@(posedge refClk) disable iff (!rstN)
    st.snapMeas |=> (st.apply || st.finish));

endmodule

// File: rtl/vco_sar_cal.sv
module vco_sar_cal
  import vco_sar_pkg::*;
#(
  parameter int CODE_W     = 8,
  parameter int CNT_W      = 12,
  parameter int WIN_CYC    = 256,
  parameter int SETTLE_CYC = 8,
  parameter int LOCK_TOL   = 6
) (
  input  logic              refClk,
  input  logic              rstN,
  input  logic              start,
  input  logic              fbClk,
  output logic [CODE_W-1:0] code,
  output logic              busy,
  output logic              done,
  output logic              locked
);

  localparam int IDX_W = $clog2(CODE_W);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  calStrobe_t       st;
  logic [IDX_W-1:0] bitIdx;
  logic [CNT_W-1:0] fbCount;

  vco_sar_fbsync #(.CNT_W(CNT_W)) uSync (
    .fbClk(fbClk), .refClk(refClk), .rstN(rstN), .fbCountRef(fbCount)
  );

  vco_sar_ctrl #(.CODE_W(CODE_W), .WIN_CYC(WIN_CYC), .SETTLE_CYC(SETTLE_CYC)) uCtrl (
    .refClk(refClk), .rstN(rstN), .start(start),
    .st(st), .bitIdx(bitIdx), .busy(busy), .done(done)
  );

  vco_sar_dp #(.CODE_W(CODE_W), .CNT_W(CNT_W), .WIN_CYC(WIN_CYC), .LOCK_TOL(LOCK_TOL)) uDp (
    .refClk(refClk), .rstN(rstN), .st(st), .bitIdx(bitIdx),
    .fbCount(fbCount), .code(code), .locked(locked)
  );

  // R2: a start accepted while not busy loads the midpoint and begins a run
  p_start_loads_mid_r2: assert property (@(posedge refClk) disable iff (!rstN)
    (start && !busy) |=> (code == MID && busy && !done && !locked));

  // R7: lock is only reported on a finished run
  p_lock_needs_done_r7: assert property (@(posedge refClk) disable iff (!rstN)
    locked |-> done);

  // R6: the final code is held while done stays high
  p_done_holds_r6: assert property (@(posedge refClk) disable iff (!rstN)
    (done && $past(done)) |-> $stable(code));

endmodule

// File: tb/tb_vco_sar_cal.sv
`timescale 1ns/1ps
module tb_vco_sar_cal;

  localparam int SETTLE = 8;
  localparam int WIN    = 256;
  localparam int RUNLEN = 9 * (SETTLE + WIN + 1);

  logic       refClk = 1'b0;
  logic       rstN   = 1'b0;
  logic       start  = 1'b0;
  logic       fbClk  = 1'b0;
  logic [7:0] code;
  logic       busy, done, locked;

  int  nChk  = 0;
  int  nFail = 0;
  real tgt   = 100.0;
  real offs  = 0.0;

  vco_sar_cal #(.WIN_CYC(WIN), .SETTLE_CYC(SETTLE)) dut (
    .refClk(refClk), .rstN(rstN), .start(start), .fbClk(fbClk),
    .code(code), .busy(busy), .done(done), .locked(locked)
  );

  always #2.5 refClk = ~refClk;

  // Oscillator plus divider model: divided frequency = fRef*(code+offs)/tgt
  initial begin
    forever begin
      if ((real'(code) + offs) <= 0.0) @(code);
      else #(2.5 * tgt / (real'(code) + offs)) fbClk = ~fbClk;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge refClk) start = 1'b1;
    @(negedge refClk) start = 1'b0;
  endtask

  // Runs until done; returns number of cycles with busy high
  task automatic runCal(input real t, input real o, output int cycles);
    tgt = t; offs = o;
    pulseStart();
    cycles = 0;
    while (busy && cycles < 4 * RUNLEN) begin
      cycles++;
      @(negedge refClk);
    end
  endtask

  task automatic tReset();
    chk(code == 8'h80, "R1", "reset code", code, 8'h80);
    chk(!busy && !done && !locked, "R1", "reset flags", {busy, done, locked}, 0);
  endtask

  task automatic tFirstStep(input real t, input int expCode);
    tgt = t; offs = 0.0;
    pulseStart();
    chk(busy && code == 8'h80, "R2", "start loads midpoint", code, 8'h80);
    repeat (SETTLE + WIN) @(negedge refClk);
    chk(code == 8'h80, "R3", "code held through window", code, 8'h80);
    @(negedge refClk);
    chk(code == expCode, "R4", "first decision", code, expCode);
    while (busy) @(negedge refClk);
  endtask

  task automatic tConverge(input real t);
    int  cyc;
    real d;
    runCal(t, 0.0, cyc);
    d = real'(code) - t;
    chk(done && !busy, "R6", "done after run", {done, busy}, 2);
    chk(cyc == RUNLEN, "R5", "run length", cyc, RUNLEN);
    chk(d <= 2.0 && d >= -2.0, "R4", "final code near target", code, int'(t));
    chk(locked, "R7", "locked on reachable target", locked, 1);
  endtask

  task automatic tHold();
    logic [7:0] held;
    held = code;
    repeat (300) @(negedge refClk);
    chk(code == held && done, "R6", "code held after done", code, held);
  endtask

  task automatic tRestart();
    pulseStart();
    chk(busy && !done && !locked && code == 8'h80, "R2", "restart clears status",
        {busy, done, locked}, 4);
    while (busy) @(negedge refClk);
  endtask

  task automatic tIgnoreStart();
    int cyc = 0;
    tgt = 100.0; offs = 0.0;
    pulseStart();
    repeat (SETTLE + WIN + 3) begin cyc++; @(negedge refClk); end
    start = 1'b1;
    @(negedge refClk) start = 1'b0;
    cyc++;
    chk(code == 8'h40 && busy, "R8", "mid-run start leaves code", code, 8'h40);
    while (busy && cyc < 4 * RUNLEN) begin cyc++; @(negedge refClk); end
    chk(cyc == RUNLEN, "R8", "mid-run start leaves run length", cyc, RUNLEN);
  endtask

  task automatic tRails();
    int cyc;
    runCal(400.0, 0.0, cyc);
    chk(code == 8'hFF, "R9", "slow rail code", code, 8'hFF);
    chk(done && !locked, "R9", "slow rail unlocked", locked, 0);
    runCal(40.0, 60.0, cyc);
    chk(code == 8'h00, "R9", "fast rail code", code, 8'h00);
    chk(done && !locked, "R9", "fast rail unlocked", locked, 0);
  endtask

  initial begin
    repeat (150000) @(posedge refClk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge refClk);
    tReset();
    rstN = 1'b1;
    repeat (3) @(negedge refClk);
    tReset();
    tFirstStep(100.0, 8'h40);
    tFirstStep(230.0, 8'hC0);
    tConverge(100.0);
    tHold();
    tConverge(163.7);
    tConverge(230.2);
    tRestart();
    tIgnoreStart();
    tRails();
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule